// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block takes a core through four nested power modes. Each mode removes a further set of resources. The first deeper mode gates only the core clock. The next stops the PLL and the bus-snoop logic and asks the regulator for a lower supply. The deepest mode stops every clock, clamps the outputs of the core domain, saves the retention registers and opens the power switch. Software picks a mode by writing a small register interface, and the hardware then carries out every step of the change in a fixed order.

The controller moves one level at a time toward the requested mode. Leaving a low-power mode, it waits for the supply to settle and for the PLL to relock before it re-enables the logic that depends on them. Both waits use cycle counts that software can program. A wake input sends the core back to the active mode from any state. A request that arrives while a change is in progress is kept until the controller is no longer busy. All control outputs are registered.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, `mode_o` is 0 (active) and `busy` is 0. `core_clk_en`, `bus_clk_en`, `pll_en` and `snoop_en` are 1. `lowv_req`, `iso_en`, `ret_save`, `ret_restore` and `sw_off` are 0.
- R2: Mode code 1 (doze) clears only `core_clk_en`. All other outputs keep their active values.
- R3: Mode code 2 (nap) keeps the core clock off. It also clears `pll_en` and `snoop_en` and sets `lowv_req`. `bus_clk_en` stays 1.
- R4: Mode code 3 (sleep) has every clock enable at 0, with `lowv_req`, `iso_en` and `sw_off` at 1.
- R5: Going into sleep takes one cycle per step, in this order: `bus_clk_en` falls, `iso_en` rises, `ret_save` pulses for one cycle, then `sw_off` rises. Whenever `sw_off` is 1, `iso_en` is 1.
- R6: Leaving sleep runs in this order: `sw_off` falls, the supply wait runs, `ret_restore` pulses for one cycle, `iso_en` falls on the next cycle, and `bus_clk_en` rises one cycle after that.
- R7: The supply wait lasts the programmed settle count plus one cycle. The settle count is written at address 1. The wait follows power-switch closure and also follows the removal of `lowv_req`. A count of 0 gives a one-cycle wait.
- R8: When leaving nap, `lowv_req` falls first. After the supply wait, `pll_en` rises. After a further wait of the relock count plus one cycle, `snoop_en` rises. The relock count is written at address 2.
- R9: A write of a mode code to address 0 in bits [1:0] moves `mode_o` one level per step toward that mode. `mode_o` never skips a level, and it changes only while `busy` is 1. `busy` stays 1 until the mode has been reached.
- R10: A wake pulse, in any mode or during any transition, returns the core to mode 0. It also discards any held request.
- R11: A mode write made while `busy` is 1 is held, and the latest such write wins. The held request starts once `busy` has been 0 for one cycle.
- R12: A write of the mode already in effect has no effect: no step runs, no output changes and `busy` stays 0. The same holds for a write to address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 mode, 1 settle count, 2 relock count |
| cfg_wdata | input | CNT_W | Write data |
| wake_i | input | 1 | Wake event |
| core_clk_en | output | 1 | Core clock enable |
| bus_clk_en | output | 1 | Enable for all remaining clocks |
| pll_en | output | 1 | PLL enable |
| snoop_en | output | 1 | Bus-snoop enable |
| lowv_req | output | 1 | Low supply voltage request |
| iso_en | output | 1 | Output clamp enable for the switched domain |
| ret_save | output | 1 | One-cycle retention save pulse |
| ret_restore | output | 1 | One-cycle retention restore pulse |
| sw_off | output | 1 | Power switch open (supply removed) |
| mode_o | output | 2 | Current mode code |
| busy | output | 1 | Transition in progress |

## Verification
The hardest cases to reach from the ports are interruptions. One is a wake that arrives while the entry sequence into sleep is part-way through its clamp and save steps. The other is a second mode write that arrives while the core is still inside a supply wait. The stimulus issues a sleep request and fires the wake a few cycles later. It also issues a write a set number of cycles after a wake-up request starts, so that both events land in the middle of a level step. The reference model then shows whether the step completes first and the controller turns around correctly. A settle and relock count of zero is also programmed, to cover the shortest waits.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef enum logic [1:0] {
      PM_ACTIVE = 2'd0,
      PM_DOZE   = 2'd1,
      PM_NAP    = 2'd2,
      PM_SLEEP  = 2'd3
   } pm_mode_e;

   typedef struct packed {
      logic core_clk;
      logic bus_clk;
      logic pll;
      logic snoop;
      logic lowv;
      logic iso;
      logic save;
      logic restore;
      logic sw_off;
   } pm_ctl_t;

   localparam pm_ctl_t PM_CTL_ACTIVE = '{core_clk: 1'b1, bus_clk: 1'b1, pll: 1'b1,
                                        snoop: 1'b1, lowv: 1'b0, iso: 1'b0,
                                        save: 1'b0, restore: 1'b0, sw_off: 1'b0};

   typedef enum logic [4:0] {
      ST_IDLE,
      ST_DN_DOZE,
      ST_DN_NAP,
      ST_DN_CLK,
      ST_DN_ISO,
      ST_DN_SAVE,
      ST_DN_OFF,
      ST_UP_ON,
      ST_UP_RUSH,
      ST_UP_RESTORE,
      ST_UP_UNISO,
      ST_UP_CLK,
      ST_UP_VOLT,
      ST_UP_VWAIT,
      ST_UP_PLL,
      ST_UP_LOCK,
      ST_UP_SNOOP,
      ST_UP_CORE
   } pm_step_e;

   localparam logic [1:0] ADDR_MODE  = 2'd0;
   localparam logic [1:0] ADDR_RAIL  = 2'd1;
   localparam logic [1:0] ADDR_RELCK = 2'd2;

   localparam int TMR_RAIL = 0;
   localparam int TMR_PLL  = 1;
   localparam int NUM_TMR  = 2;

endpackage

// File: rtl/pmc_timer.sv
module pmc_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   if (W < 1) begin : g_bad_w
      $error("pmc_timer: W must be at least 1");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - W'(1);
      end
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/pmc_req.sv
module pmc_req
   import pmc_pkg::*;
#(
   parameter int W        = 8,
   parameter int RAIL_RST = 4,
   parameter int PLL_RST  = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [1:0]   wr_addr,
   input  logic [W-1:0] wr_data,
   input  logic         wake,
   input  logic         busy,
   output pm_mode_e     tgt,
   output logic [W-1:0] rail_cfg,
   output logic [W-1:0] pll_cfg
);

   pm_mode_e pend;
   logic     pend_v;
   logic     mode_wr;

   assign mode_wr = wr_en && (wr_addr == ADDR_MODE);

   // settle counts, loaded only through their own addresses
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rail_cfg <= W'(RAIL_RST);
         pll_cfg  <= W'(PLL_RST);
      end else if (wr_en) begin
         if (wr_addr == ADDR_RAIL)  rail_cfg <= wr_data;
         if (wr_addr == ADDR_RELCK) pll_cfg  <= wr_data;
      end
   end

   // wake first, then direct or held request, then promotion of a held one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt    <= PM_ACTIVE;
         pend   <= PM_ACTIVE;
         pend_v <= 1'b0;
      end else if (wake) begin
         tgt    <= PM_ACTIVE;
         pend_v <= 1'b0;
      end else if (mode_wr) begin
         if (busy) begin
            pend   <= pm_mode_e'(wr_data[1:0]);
            pend_v <= 1'b1;
         end else begin
            tgt    <= pm_mode_e'(wr_data[1:0]);
            pend_v <= 1'b0;
         end
      end else if (!busy && pend_v) begin
         tgt    <= pend;
         pend_v <= 1'b0;
      end
   end

endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
   import pmc_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  pm_mode_e     tgt,
   input  logic [W-1:0] rail_cfg,
   input  logic [W-1:0] pll_cfg,
   output pm_mode_e     cur,
   output pm_ctl_t      ctl,
   output logic         idle
);

   pm_step_e             st;
   logic [NUM_TMR-1:0]   tmr_load;
   logic [NUM_TMR-1:0]   tmr_exp;
   logic [W-1:0]         tmr_val [NUM_TMR];

   assign tmr_val[TMR_RAIL] = rail_cfg;
   assign tmr_val[TMR_PLL]  = pll_cfg;

   always_comb begin
      tmr_load           = '0;
      tmr_load[TMR_RAIL] = (st == ST_UP_ON) || (st == ST_UP_VOLT);
      tmr_load[TMR_PLL]  = (st == ST_UP_PLL);
   end

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
      pmc_timer #(.W(W)) u_tmr (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (tmr_load[i]),
         .load_val (tmr_val[i]),
         .expired  (tmr_exp[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cur <= PM_ACTIVE;
         ctl <= PM_CTL_ACTIVE;
      end else begin
         ctl.save    <= 1'b0;
         ctl.restore <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (tgt > cur) begin
                  unique case (cur)
                     PM_ACTIVE: st <= ST_DN_DOZE;
                     PM_DOZE:   st <= ST_DN_NAP;
                     default:   st <= ST_DN_CLK;
                  endcase
               end else if (tgt < cur) begin
                  unique case (cur)
                     PM_SLEEP: st <= ST_UP_ON;
                     PM_NAP:   st <= ST_UP_VOLT;
                     default:  st <= ST_UP_CORE;
                  endcase
               end
            end
            // entry steps
            ST_DN_DOZE: begin
               ctl.core_clk <= 1'b0;
               cur          <= PM_DOZE;
               st           <= ST_IDLE;
            end
            ST_DN_NAP: begin
               ctl.pll   <= 1'b0;
               ctl.snoop <= 1'b0;
               ctl.lowv  <= 1'b1;
               cur       <= PM_NAP;
               st        <= ST_IDLE;
            end
            ST_DN_CLK: begin
               ctl.bus_clk <= 1'b0;
               st          <= ST_DN_ISO;
            end
            ST_DN_ISO: begin
               ctl.iso <= 1'b1;
               st      <= ST_DN_SAVE;
            end
            ST_DN_SAVE: begin
               ctl.save <= 1'b1;
               st       <= ST_DN_OFF;
            end
            ST_DN_OFF: begin
               ctl.sw_off <= 1'b1;
               cur        <= PM_SLEEP;
               st         <= ST_IDLE;
            end
            // exit steps
            ST_UP_ON: begin
               ctl.sw_off <= 1'b0;
               st         <= ST_UP_RUSH;
            end
            ST_UP_RUSH: begin
               if (tmr_exp[TMR_RAIL]) st <= ST_UP_RESTORE;
            end
            ST_UP_RESTORE: begin
               ctl.restore <= 1'b1;
               st          <= ST_UP_UNISO;
            end
            ST_UP_UNISO: begin
               ctl.iso <= 1'b0;
               st      <= ST_UP_CLK;
            end
            ST_UP_CLK: begin
               ctl.bus_clk <= 1'b1;
               cur         <= PM_NAP;
               st          <= ST_IDLE;
            end
            ST_UP_VOLT: begin
               ctl.lowv <= 1'b0;
               st       <= ST_UP_VWAIT;
            end
            ST_UP_VWAIT: begin
               if (tmr_exp[TMR_RAIL]) st <= ST_UP_PLL;
            end
            ST_UP_PLL: begin
               ctl.pll <= 1'b1;
               st      <= ST_UP_LOCK;
            end
            ST_UP_LOCK: begin
               if (tmr_exp[TMR_PLL]) st <= ST_UP_SNOOP;
            end
            ST_UP_SNOOP: begin
               ctl.snoop <= 1'b1;
               cur       <= PM_DOZE;
               st        <= ST_IDLE;
            end
            ST_UP_CORE: begin
               ctl.core_clk <= 1'b1;
               cur          <= PM_ACTIVE;
               st           <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign idle = (st == ST_IDLE);

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
   import pmc_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int RAIL_RST  = 4,
   parameter int PLL_RST   = 6,
   parameter int SYNC_WAKE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_addr,
   input  logic [CNT_W-1:0] cfg_wdata,
   input  logic             wake_i,
   output logic             core_clk_en,
   output logic             bus_clk_en,
   output logic             pll_en,
   output logic             snoop_en,
   output logic             lowv_req,
   output logic             iso_en,
   output logic             ret_save,
   output logic             ret_restore,
   output logic             sw_off,
   output logic [1:0]       mode_o,
   output logic             busy
);

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
      $error("pwr_mode_seq: CNT_W must lie in 2..32");
   end
   if (RAIL_RST < 0 || (RAIL_RST >> CNT_W) != 0) begin : g_bad_rail
      $error("pwr_mode_seq: RAIL_RST does not fit CNT_W");
   end
   if (PLL_RST < 0 || (PLL_RST >> CNT_W) != 0) begin : g_bad_pll
      $error("pwr_mode_seq: PLL_RST does not fit CNT_W");
   end

   logic             wake_s;
   pm_mode_e         tgt_mode;
   pm_mode_e         cur_mode;
   pm_ctl_t          ctl;
   logic             seq_idle;
   logic [CNT_W-1:0] rail_cfg;
   logic [CNT_W-1:0] pll_cfg;

   if (SYNC_WAKE != 0) begin : g_wake_sync
      logic [1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= '0;
         else        sr <= {sr[0], wake_i};
      end
      assign wake_s = sr[1];
   end else begin : g_wake_direct
      assign wake_s = wake_i;
   end

   assign busy = !seq_idle || (cur_mode != tgt_mode);

   pmc_req #(
      .W        (CNT_W),
      .RAIL_RST (RAIL_RST),
      .PLL_RST  (PLL_RST)
   ) u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_addr  (cfg_addr),
      .wr_data  (cfg_wdata),
      .wake     (wake_s),
      .busy     (busy),
      .tgt      (tgt_mode),
      .rail_cfg (rail_cfg),
      .pll_cfg  (pll_cfg)
   );

   pmc_seq #(.W(CNT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tgt      (tgt_mode),
      .rail_cfg (rail_cfg),
      .pll_cfg  (pll_cfg),
      .cur      (cur_mode),
      .ctl      (ctl),
      .idle     (seq_idle)
   );

   assign core_clk_en = ctl.core_clk;
   assign bus_clk_en  = ctl.bus_clk;
   assign pll_en      = ctl.pll;
   assign snoop_en    = ctl.snoop;
   assign lowv_req    = ctl.lowv;
   assign iso_en      = ctl.iso;
   assign ret_save    = ctl.save;
   assign ret_restore = ctl.restore;
   assign sw_off      = ctl.sw_off;
   assign mode_o      = cur_mode;

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_wr,
   input logic [1:0]       req_mode,
   input logic             wake_s,
   input logic             core_clk_en,
   input logic             bus_clk_en,
   input logic             pll_en,
   input logic             snoop_en,
   input logic             lowv_req,
   input logic             iso_en,
   input logic             ret_save,
   input logic             ret_restore,
   input logic             sw_off,
   input logic [1:0]       mode_o,
   input logic             busy,
   input logic [CNT_W-1:0] rail_cfg,
   input logic [CNT_W-1:0] pll_cfg
);

   localparam int CW = CNT_W + 1;

   logic [CW-1:0] on_cnt;
   logic [CW-1:0] lock_cnt;

   // cycles since the supply switch closed, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               on_cnt <= '0;
      else if (sw_off)          on_cnt <= '0;
      else if (on_cnt != '1)    on_cnt <= on_cnt + CW'(1);
   end

   // cycles since the PLL was enabled, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               lock_cnt <= '0;
      else if (!pll_en)         lock_cnt <= '0;
      else if (lock_cnt != '1)  lock_cnt <= lock_cnt + CW'(1);
   end

   a_r2_doze_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && mode_o == 2'd1) |-> (!core_clk_en && bus_clk_en && pll_en && snoop_en &&
                                     !lowv_req && !iso_en && !sw_off));

   a_r3_nap_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && mode_o == 2'd2) |-> (!core_clk_en && bus_clk_en && !pll_en && !snoop_en &&
                                     lowv_req && !iso_en && !sw_off));

   a_r4_sleep_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && mode_o == 2'd3) |-> (!core_clk_en && !bus_clk_en && !pll_en && !snoop_en &&
                                     lowv_req && iso_en && sw_off));

   a_r5_iso_after_clk_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iso_en) |-> !bus_clk_en);

   a_r5_save_while_clamped: assert property (@(posedge clk) disable iff (!rst_n)
      ret_save |-> (iso_en && !sw_off && !bus_clk_en));

   a_r5_off_after_save: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_off) |-> $past(ret_save));

   a_r5_clamped_while_off: assert property (@(posedge clk) disable iff (!rst_n)
      sw_off |-> iso_en);

   a_r6_restore_powered: assert property (@(posedge clk) disable iff (!rst_n)
      ret_restore |-> (!sw_off && iso_en));

   a_r6_unclamp_after_restore: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(iso_en) |-> $past(ret_restore));

   a_r6_clk_after_unclamp: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_clk_en) |-> !iso_en);

   a_r7_rush_wait: assert property (@(posedge clk) disable iff (!rst_n)
      ret_restore |-> (on_cnt > {1'b0, rail_cfg}));

   a_r8_pll_after_voltage: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_en) |-> !lowv_req);

   a_r8_lock_wait: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(snoop_en) |-> (pll_en && lock_cnt > {1'b0, pll_cfg}));

   a_r9_mode_moves_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != $past(mode_o)) |-> $past(busy));

   a_r9_single_level: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != $past(mode_o)) |-> ((mode_o - $past(mode_o) == 2'd1) ||
                                     (mode_o - $past(mode_o) == 2'd3)));

   a_r10_wake_heads_active: assert property (@(posedge clk) disable iff (!rst_n)
      wake_s |=> (busy || mode_o == 2'd0));

   a_r12_same_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && !busy && !wake_s && req_mode == mode_o) |=>
         (!busy && $stable({core_clk_en, bus_clk_en, pll_en, snoop_en, lowv_req,
                            iso_en, ret_save, ret_restore, sw_off, mode_o})));

endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_wr     (cfg_we && (cfg_addr == 2'd0)),
   .req_mode    (cfg_wdata[1:0]),
   .wake_s      (wake_s),
   .core_clk_en (core_clk_en),
   .bus_clk_en  (bus_clk_en),
   .pll_en      (pll_en),
   .snoop_en    (snoop_en),
   .lowv_req    (lowv_req),
   .iso_en      (iso_en),
   .ret_save    (ret_save),
   .ret_restore (ret_restore),
   .sw_off      (sw_off),
   .mode_o      (mode_o),
   .busy        (busy),
   .rail_cfg    (rail_cfg),
   .pll_cfg     (pll_cfg)
);

// File: tb/tb_pwr_mode_seq.sv
`timescale 1ns/1ps
module tb_pwr_mode_seq;

   localparam int CNT_W = 8;
   // expected-vector bit positions
   localparam int B_CORE = 8, B_BUS = 7, B_PLL = 6, B_SNP = 5, B_LOWV = 4;
   localparam int B_ISO = 3, B_SAVE = 2, B_REST = 1, B_OFF = 0;
   localparam logic [8:0] V_ACTIVE = 9'b1111_0000_0;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic [1:0]       cfg_addr = 2'd0;
   logic [CNT_W-1:0] cfg_wdata = '0;
   logic             wake_i = 1'b0;
   logic core_clk_en, bus_clk_en, pll_en, snoop_en, lowv_req;
   logic iso_en, ret_save, ret_restore, sw_off, busy;
   logic [1:0] mode_o;

   pwr_mode_seq #(.CNT_W(CNT_W), .RAIL_RST(4), .PLL_RST(6), .SYNC_WAKE(0)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .wake_i(wake_i),
      .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en), .pll_en(pll_en),
      .snoop_en(snoop_en), .lowv_req(lowv_req), .iso_en(iso_en),
      .ret_save(ret_save), .ret_restore(ret_restore), .sw_off(sw_off),
      .mode_o(mode_o), .busy(busy)
   );

   always #5 clk = ~clk;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    chk_on = 1'b0;
   bit    done = 1'b0;
   string req = "R1";

   // ---------------- reference model ----------------
   logic [10:0] q[$];
   int          m_cur, m_tgt, m_pend, m_rail, m_pll;
   bit          m_pv, m_b;
   logic [8:0]  m_out;
   logic [10:0] m_e;

   task automatic push(input int mode, input logic [8:0] v);
      q.push_back({2'(mode), v});
   endtask

   task automatic plan_step();
      logic [8:0] v;
      v = m_out;
      if (m_tgt > m_cur) begin
         case (m_cur)
            0: begin v[B_CORE] = 0; push(1, v); end
            1: begin v[B_PLL] = 0; v[B_SNP] = 0; v[B_LOWV] = 1; push(2, v); end
            default: begin
               v[B_BUS] = 0;  push(2, v);
               v[B_ISO] = 1;  push(2, v);
               v[B_SAVE] = 1; push(2, v);
               v[B_SAVE] = 0; v[B_OFF] = 1; push(3, v);
            end
         endcase
      end else begin
         case (m_cur)
            3: begin
               v[B_OFF] = 0; push(3, v);
               for (int i = 0; i <= m_rail; i++) push(3, v);
               v[B_REST] = 1; push(3, v);
               v[B_REST] = 0; v[B_ISO] = 0; push(3, v);
               v[B_BUS] = 1; push(2, v);
            end
            2: begin
               v[B_LOWV] = 0; push(2, v);
               for (int i = 0; i <= m_rail; i++) push(2, v);
               v[B_PLL] = 1; push(2, v);
               for (int i = 0; i <= m_pll; i++) push(2, v);
               v[B_SNP] = 1; push(1, v);
            end
            default: begin v[B_CORE] = 1; push(0, v); end
         endcase
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         m_cur = 0; m_tgt = 0; m_pend = 0; m_pv = 0;
         m_rail = 4; m_pll = 6; m_out = V_ACTIVE;
      end else begin
         m_b = (q.size() != 0) || (m_cur != m_tgt);
         if (q.size() == 0) begin
            if (m_cur != m_tgt) plan_step();
         end else begin
            m_e = q.pop_front();
            m_cur = int'(m_e[10:9]);
            m_out = m_e[8:0];
         end
         if (cfg_we && cfg_addr == 2'd1) m_rail = int'(cfg_wdata);
         if (cfg_we && cfg_addr == 2'd2) m_pll = int'(cfg_wdata);
         if (wake_i) begin
            m_tgt = 0; m_pv = 0;
         end else if (cfg_we && cfg_addr == 2'd0) begin
            if (m_b) begin m_pend = int'(cfg_wdata[1:0]); m_pv = 1; end
            else     begin m_tgt = int'(cfg_wdata[1:0]); m_pv = 0; end
         end else if (!m_b && m_pv) begin
            m_tgt = m_pend; m_pv = 0;
         end
      end
   end

   function automatic bit model_busy();
      return (q.size() != 0) || (m_cur != m_tgt);
   endfunction

   // ---------------- per-cycle comparison ----------------
   always @(negedge clk) begin
      if (chk_on && !done) begin
         logic [11:0] act, exp;
         act = {mode_o, core_clk_en, bus_clk_en, pll_en, snoop_en, lowv_req,
                iso_en, ret_save, ret_restore, sw_off, busy};
         exp = {2'(m_cur), m_out, model_busy()};
         n_cmp++;
         if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle compare at %0t: got %b expected %b", req, $time, act, exp);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", r, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wake_pulse();
      @(negedge clk);
      wake_i = 1'b1;
      @(negedge clk);
      wake_i = 1'b0;
   endtask

   task automatic settle();
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (!model_busy() && !m_pv) break;
      end
      @(negedge clk);
   endtask

   task automatic go(input int mode);
      wr(2'd0, CNT_W'(mode));
      settle();
      chk(req, 32'(mode_o), 32'(mode));
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got hung run expected completion");
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_on = 1'b1;
      @(negedge clk);
      req = "R1";
      chk("R1", {23'd0, mode_o, core_clk_en, bus_clk_en, pll_en, snoop_en, lowv_req,
                 iso_en, ret_save, ret_restore, sw_off},
                {23'd0, 2'd0, V_ACTIVE});
      chk("R1", 32'(busy), 32'd0);

      req = "R2";  go(1);
      chk("R2", {31'd0, core_clk_en}, 32'd0);
      req = "R12"; wr(2'd0, 8'd1);
      chk("R12", 32'(busy), 32'd0);
      wr(2'd3, 8'd3);
      chk("R12", 32'(busy), 32'd0);
      chk("R12", 32'(mode_o), 32'd1);
      req = "R3";  go(2);
      chk("R3", {31'd0, lowv_req}, 32'd1);
      req = "R5";  go(3);
      req = "R4";  chk("R4", {31'd0, sw_off}, 32'd1);
      req = "R7";  wr(2'd1, 8'd3); wr(2'd2, 8'd5);
      req = "R6";  go(0);
      req = "R8";  chk("R8", {31'd0, snoop_en}, 32'd1);

      req = "R9";  go(3);
      go(1);
      go(2);
      go(0);

      req = "R10"; go(3);
      wake_pulse(); settle();
      chk("R10", 32'(mode_o), 32'd0);
      wr(2'd0, 8'd3);
      repeat (4) @(negedge clk);
      wake_pulse(); settle();
      chk("R10", 32'(mode_o), 32'd0);
      wr(2'd0, 8'd2);
      repeat (3) @(negedge clk);
      wake_pulse(); settle();
      chk("R10", 32'(mode_o), 32'd0);

      req = "R11"; wr(2'd0, 8'd2);
      wr(2'd0, 8'd3);
      wr(2'd0, 8'd1);
      settle();
      chk("R11", 32'(mode_o), 32'd1);
      go(3);
      wr(2'd0, 8'd0);
      repeat (3) @(negedge clk);
      wr(2'd0, 8'd2);
      settle();
      chk("R11", 32'(mode_o), 32'd2);

      req = "R7";  go(0);
      wr(2'd1, 8'd0); wr(2'd2, 8'd0);
      go(3);
      go(0);
      chk("R7", {31'd0, bus_clk_en}, 32'd1);

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule